// File: doc/BRIEF.md
# Per-Wavefront Lost-Locality Detector

This block sits next to a set-associative L1 data cache that many hardware thread groups (wavefronts) share. Each cache line keeps the ID of the wavefront that allocated it. When the cache evicts a line, it reports the line's address tag and owner ID. The detector files that tag into a small victim store that belongs to the owner. A separate victim store exists for every wavefront context.

When a later access misses in the cache, the detector searches only the victim store of the requesting wavefront for the missing tag. A match means the wavefront lost data it had brought in itself, because other traffic pushed it out. For each such match the block raises a one-cycle lost-locality event that carries the wavefront ID. A scheduler can use these events to reduce how many wavefronts run at once. The data array, the fill path and the lower memory levels are outside this block.

The cache geometry parameters set the tag width. With the defaults (32-bit address, 128-byte lines, 32 sets, 8 ways) the tag is 20 bits wide.

Top module: `lost_locality_detector`

## Requirements
- R1: Reset clears every victim entry in every wavefront group. After reset, a miss produces no event until an eviction has filed a matching tag, and `lost_valid` is low.
- R2: An eviction files its tag in the group of `evict_owner`. A later miss from that same wavefront with that tag produces an event.
- R3: A miss from a wavefront other than the recorded owner of an evicted tag produces no event, even when the tags are equal.
- R4: An event appears as `lost_valid` high for exactly one cycle. It appears in the cycle after the clock edge that samples the miss. `lost_wid` equals the `miss_wid` of that miss.
- R5: Each group holds 4 entries and replaces them oldest-first. The fifth eviction into a group overwrites the first tag filed there, and the later four remain detectable.
- R6: A miss that matches a victim entry invalidates that entry, so a second miss with the same tag produces no further event.
- R7: When an eviction and a miss arrive in the same cycle, the miss is checked against the victim contents from before that eviction is filed. The filed tag can be detected by a miss from its owner in a later cycle.
- R8: Without `miss_valid`, no event is produced. An eviction on its own never raises `lost_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | An L1 miss is presented this cycle |
| miss_wid | input | 5 | Wavefront ID of the missing access |
| miss_tag | input | 20 | Address tag of the missing access |
| evict_valid | input | 1 | An L1 eviction is presented this cycle |
| evict_owner | input | 5 | Recorded allocating wavefront of the evicted line |
| evict_tag | input | 20 | Address tag of the evicted line |
| lost_valid | output | 1 | One-cycle lost-locality event |
| lost_wid | output | 5 | Wavefront ID of the event |

## Verification
The bench builds the block with its default parameters: 32 wavefront groups, 4 entries per group, and a 20-bit tag. It draws random wavefront IDs from a narrow range and random tags from a pool of eight values. This makes repeat hits, cross-wavefront tag collisions, group overflow and same-cycle eviction-with-miss collisions common. Directed sequences then pin down the oldest-first overwrite, the invalidation after a hit, and the clearing at reset.

// File: rtl/vtd_pkg.sv
// Package: shared default geometry for the lost-locality detector.
// Assumes: the values describe the L1 that reports the miss and eviction events.
package vtd_pkg;
    localparam int unsigned VTD_WAVES      = 32;
    localparam int unsigned VTD_DEPTH      = 4;
    localparam int unsigned VTD_ADDR_W     = 32;
    localparam int unsigned VTD_LINE_BYTES = 128;
    localparam int unsigned VTD_SETS       = 32;
endpackage

// File: rtl/vtd_tag_group.sv
// Module: victim tag store of one wavefront.
// What it does: a fully associative, FIFO-replaced tag store with one valid bit per entry.
//   The probe compares against the stored contents before any write in the same cycle.
//   A probe hit clears every matching entry. An insert then writes at the FIFO pointer,
//   and if both touch the same slot the insert wins.
// Assumes: DEPTH >= 2.
module vtd_tag_group #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic             prb_en,
    input  logic [TAG_W-1:0] prb_tag,
    output logic             hit
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [DEPTH-1:0]       ent_vld;
    logic [TAG_W-1:0]       ent_tag [DEPTH];
    logic [PTR_W-1:0]       wr_ptr;
    logic [DEPTH-1:0]       match;

    // Compare the probe tag with every valid entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            match[i] = prb_en && ent_vld[i] && (ent_tag[i] == prb_tag);
        end
    end

    assign hit = |match;

    // Advance the FIFO pointer on each insert, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (ins_en) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Per entry: clear on a probe hit, then let an insert overwrite.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[g] <= 1'b0;
                ent_tag[g] <= '0;
            end else if (ins_en && (wr_ptr == PTR_W'(g))) begin
                ent_vld[g] <= 1'b1;
                ent_tag[g] <= ins_tag;
            end else if (match[g]) begin
                ent_vld[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vtd_event_reg.sv
// Module: output register for the lost-locality event.
// What it does: captures a hit and its wavefront ID, giving a one-cycle pulse one clock later.
// Assumes: the hit input is already qualified by a valid miss.
module vtd_event_reg #(
    parameter int unsigned WID_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_in,
    input  logic [WID_W-1:0] wid_in,
    output logic             valid_out,
    output logic [WID_W-1:0] wid_out
);
    // Register the event; the valid bit clears whenever no hit is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            wid_out   <= '0;
        end else begin
            valid_out <= hit_in;
            wid_out   <= hit_in ? wid_in : '0;
        end
    end
endmodule

// File: rtl/lost_locality_detector.sv
// Module: top of the per-wavefront lost-locality detector.
// What it does: routes each eviction to its owner's victim group and each miss
//   to the requester's group, then registers any hit as a lost-locality event.
// Assumes: at most one miss and one eviction per cycle; N_WAVES is a power of two.
module lost_locality_detector
    import vtd_pkg::*;
#(
    parameter int unsigned N_WAVES    = VTD_WAVES,
    parameter int unsigned DEPTH      = VTD_DEPTH,
    parameter int unsigned ADDR_W     = VTD_ADDR_W,
    parameter int unsigned LINE_BYTES = VTD_LINE_BYTES,
    parameter int unsigned SETS       = VTD_SETS,
    localparam int unsigned WID_W     = $clog2(N_WAVES),
    localparam int unsigned TAG_W     = ADDR_W - $clog2(LINE_BYTES) - $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [WID_W-1:0] miss_wid,
    input  logic [TAG_W-1:0] miss_tag,
    input  logic             evict_valid,
    input  logic [WID_W-1:0] evict_owner,
    input  logic [TAG_W-1:0] evict_tag,
    output logic             lost_valid,
    output logic [WID_W-1:0] lost_wid
);
    logic [N_WAVES-1:0] grp_hit;
    logic               any_hit;

    // One victim group per wavefront context, selected by owner or requester ID.
    for (genvar w = 0; w < N_WAVES; w++) begin : g_grp
        vtd_tag_group #(
            .DEPTH (DEPTH),
            .TAG_W (TAG_W)
        ) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .ins_en  (evict_valid && (evict_owner == WID_W'(w))),
            .ins_tag (evict_tag),
            .prb_en  (miss_valid && (miss_wid == WID_W'(w))),
            .prb_tag (miss_tag),
            .hit     (grp_hit[w])
        );
    end

    assign any_hit = |grp_hit;

    vtd_event_reg #(
        .WID_W (WID_W)
    ) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_in    (any_hit),
        .wid_in    (miss_wid),
        .valid_out (lost_valid),
        .wid_out   (lost_wid)
    );
endmodule

// File: rtl/vtd_checker.sv
// Module: assertion checker bound to the lost-locality detector.
// What it does: checks event timing, ID, probe isolation and reset behaviour.
// Assumes: it is attached through the bind statement at the end of this file.
module vtd_checker #(
    parameter int unsigned N_WAVES = 32,
    parameter int unsigned WID_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               miss_valid,
    input logic [WID_W-1:0]   miss_wid,
    input logic               lost_valid,
    input logic [WID_W-1:0]   lost_wid,
    input logic [N_WAVES-1:0] grp_hit
);
    initial begin
        AST_GEOMETRY_SANE: assert (N_WAVES == (1 << WID_W)); // R4
    end

    AST_EVENT_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        lost_valid |-> $past(miss_valid)); // R8

    AST_EVENT_WID: assert property (@(posedge clk) disable iff (!rst_n)
        lost_valid |-> (lost_wid == $past(miss_wid))); // R4

    AST_ONE_GROUP_PROBED: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_hit)); // R3

    AST_HIT_ONLY_OWN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_hit != '0) |-> (miss_valid && grp_hit[miss_wid])); // R3

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lost_valid); // R1
endmodule

bind lost_locality_detector vtd_checker #(
    .N_WAVES (N_WAVES),
    .WID_W   (WID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_wid   (miss_wid),
    .lost_valid (lost_valid),
    .lost_wid   (lost_wid),
    .grp_hit    (grp_hit)
);

// File: tb/sim_lost_locality_detector.sv
module sim_lost_locality_detector;
    localparam int NW  = 32;
    localparam int DP  = 4;
    localparam int WW  = 5;
    localparam int TW  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [WW-1:0] miss_wid = '0;
    logic [TW-1:0] miss_tag = '0;
    logic          evict_valid = 1'b0;
    logic [WW-1:0] evict_owner = '0;
    logic [TW-1:0] evict_tag = '0;
    logic          lost_valid;
    logic [WW-1:0] lost_wid;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // Reference model of the victim stores.
    logic          m_vld [NW][DP];
    logic [TW-1:0] m_tag [NW][DP];
    int            m_ptr [NW];

    lost_locality_detector u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_wid(miss_wid), .miss_tag(miss_tag),
        .evict_valid(evict_valid), .evict_owner(evict_owner), .evict_tag(evict_tag),
        .lost_valid(lost_valid), .lost_wid(lost_wid)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    function automatic void model_clear();
        for (int w = 0; w < NW; w++) begin
            m_ptr[w] = 0;
            for (int i = 0; i < DP; i++) begin
                m_vld[w][i] = 1'b0;
                m_tag[w][i] = '0;
            end
        end
    endfunction

    // Step the model one cycle: probe old contents, clear matches, then insert.
    function automatic logic model_step(logic mv, logic [WW-1:0] mw, logic [TW-1:0] mt,
                                        logic ev, logic [WW-1:0] eo, logic [TW-1:0] et);
        logic h = 1'b0;
        if (mv) begin
            for (int i = 0; i < DP; i++) begin
                if (m_vld[mw][i] && m_tag[mw][i] == mt) begin
                    h = 1'b1;
                    m_vld[mw][i] = 1'b0;
                end
            end
        end
        if (ev) begin
            m_vld[eo][m_ptr[eo]] = 1'b1;
            m_tag[eo][m_ptr[eo]] = et;
            m_ptr[eo] = (m_ptr[eo] + 1) % DP;
        end
        return h;
    endfunction

    task automatic check(string req, logic ev, logic [WW-1:0] ew);
        vectors = vectors + 1;
        if (lost_valid !== ev || (ev && lost_wid !== ew)) begin
            errors = errors + 1;
            $display("FAIL %s: actual valid=%0b wid=%0d expected valid=%0b wid=%0d",
                     req, lost_valid, lost_wid, ev, ew);
        end
    endtask

    // One cycle: drive, clock, then check the registered result just after the edge.
    task automatic cyc(string req, logic mv, logic [WW-1:0] mw, logic [TW-1:0] mt,
                       logic ev, logic [WW-1:0] eo, logic [TW-1:0] et);
        logic exp_h;
        miss_valid = mv; miss_wid = mw; miss_tag = mt;
        evict_valid = ev; evict_owner = eo; evict_tag = et;
        exp_h = model_step(mv, mw, mt, ev, eo, et);
        @(posedge clk); #1;
        check(req, exp_h, mw);
    endtask

    task automatic idle(string req);
        cyc(req, 1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        miss_valid = 1'b0; evict_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model_clear();
        do_reset();
        vectors = vectors + 1;
        if (lost_valid !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R1: actual valid=%0b expected valid=0", lost_valid);
        end

        // R1: misses right after reset find nothing
        cyc("R1", 1'b1, 5'd3, 20'h00ABC, 1'b0, '0, '0);

        // R8: eviction alone gives no event
        cyc("R8", 1'b0, '0, '0, 1'b1, 5'd7, 20'h12345);
        // R3: other wavefront misses on the same tag
        cyc("R3", 1'b1, 5'd8, 20'h12345, 1'b0, '0, '0);
        // R2 / R4: owner misses, pulse with its ID
        cyc("R2", 1'b1, 5'd7, 20'h12345, 1'b0, '0, '0);
        // R4: pulse lasts one cycle
        idle("R4");
        // R6: entry was invalidated by the hit
        cyc("R6", 1'b1, 5'd7, 20'h12345, 1'b0, '0, '0);

        // R5: five evictions into group 31, oldest overwritten
        for (int k = 0; k < 5; k++) cyc("R5", 1'b0, '0, '0, 1'b1, 5'd31, TW'(20'h100 + k));
        cyc("R5", 1'b1, 5'd31, 20'h100, 1'b0, '0, '0);
        cyc("R5", 1'b1, 5'd31, 20'h101, 1'b0, '0, '0);
        cyc("R5", 1'b1, 5'd31, 20'h104, 1'b0, '0, '0);

        // R7: eviction and miss with the same tag and wavefront in one cycle
        cyc("R7", 1'b1, 5'd2, 20'h0BEEF, 1'b1, 5'd2, 20'h0BEEF);
        cyc("R7", 1'b1, 5'd2, 20'h0BEEF, 1'b0, '0, '0);

        // R1: reset wipes filed tags
        cyc("R1", 1'b0, '0, '0, 1'b1, 5'd4, 20'h00777);
        do_reset();
        cyc("R1", 1'b1, 5'd4, 20'h00777, 1'b0, '0, '0);

        // R4 / R2 / R3 / R5 / R6 / R7 / R8: random mix on a small ID and tag pool
        for (int n = 0; n < 4000; n++) begin
            logic          mv = ($urandom % 3) != 0;
            logic          ev = ($urandom % 2) != 0;
            logic [WW-1:0] mw = WW'($urandom % 4);
            logic [WW-1:0] eo = WW'($urandom % 4);
            logic [TW-1:0] mt = TW'($urandom % 8);
            logic [TW-1:0] et = TW'($urandom % 8);
            cyc("R4", mv, mw, mt, ev, eo, et);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule